// File: doc/BRIEF.md
# Sequential Palette Colour Loader

This block holds a colour look-up table of 256 entries, each made of three 8-bit components, and loads it through a small window of 32-bit registers. To load an entry, the host writes the entry number to a pointer register. It then writes a single colour register three times in a row. The writes supply red, then green, then blue. After each blue write the pointer steps to the next entry, so a whole table can be streamed with one pointer write followed by a run of colour writes.

Every accepted component write produces a one-cycle update pulse. The pulse carries the entry number, which component changed and its new value, so a downstream shadow copy can follow. A combinational look-up port returns the stored colour of any entry. After reset, a sequencer fills the table one entry per cycle. While it runs, the bus is held off.

Top module: `palette_dac_port`

## Requirements
- R1: After reset is released, `initBusy` is high and `busReady` is low for exactly 256 clock cycles. After that, `initBusy` is low and `busReady` is high.
- R2: Once initialisation ends, entries 0 to 254 read back as 0x000000 on `lookRgb`, and entry 255 reads back as 0xFFFFFF.
- R3: An accepted write to byte offset 0 loads the entry pointer from bits 31:24 of the write data. Bits 23:0 of the write data are ignored.
- R4: Successive accepted writes to byte offset 4 store bits 31:24 into red, green and blue of the pointed entry, in that order. `lookRgb` packs red in bits 23:16, green in 15:8 and blue in 7:0.
- R5: After the blue write, the pointer increments modulo 256, so 255 wraps to 0, and the next colour write targets red.
- R6: Each accepted colour write gives `updStrobe` high for exactly the following cycle. With it come `updIdx`, `updComp` (0 red, 1 green, 2 blue) and `updData`, equal to the entry, component and value just written.
- R7: A pointer write in the middle of a triplet restarts the sequence at red.
- R8: `busRdata` is zero for reads at any offset, and reads change neither the table nor the pointer or phase.
- R9: Writes to byte offsets 8 and 12 are ignored.
- R10: Writes whose byte enables `busBe` are not all ones (4'hF) are ignored and leave the pointer and phase unchanged.
- R11: Writes presented while `busReady` is low are not accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write request |
| busRd | input | 1 | Read request |
| busAddr | input | 4 | Byte offset in the register window |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte enables; only 4'hF is a valid write |
| busRdata | output | 32 | Read data, always zero |
| busReady | output | 1 | High when bus writes can be accepted |
| initBusy | output | 1 | High while the table is being initialised |
| updStrobe | output | 1 | One-cycle pulse per component update |
| updIdx | output | 8 | Entry of the update |
| updComp | output | 2 | Component of the update: 0 red, 1 green, 2 blue |
| updData | output | 8 | New component value |
| lookIdx | input | 8 | Entry to look up |
| lookRgb | output | 24 | Colour of `lookIdx`, red in the top byte |

## Verification
Colour triplets are loaded with distinct byte values in every component, and the low 24 data bits are set to noise. A swapped component order or a wrong data field therefore shows up as a wrong byte. Streams that cross entry 255 separate a correct modulo wrap from a saturating or stuck pointer. Pointer writes in the middle of a triplet, reads between writes, writes to the spare offsets, partial byte enables, and writes made during initialisation are each followed by a colour write. The update pulse from that write shows whether the phase or the pointer was disturbed.

// File: rtl/palette_dac_pkg.sv
package palette_dac_pkg;
  parameter int PAL_IDX_W  = 8;
  parameter int PAL_COMP_W = 8;
  parameter int PAL_NCOMP  = 3;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  typedef struct packed {
    logic                  wrComp;
    phase_e                comp;
    logic                  wrInit;
    logic                  initWhite;
    logic [PAL_IDX_W-1:0]  idx;
    logic [PAL_COMP_W-1:0] data;
  } pal_strobe_t;
endpackage

// File: rtl/palette_dac_ctrl.sv
module palette_dac_ctrl
  import palette_dac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [3:0]        busBe,
  output logic              busy,
  output pal_strobe_t       st
);
  localparam logic [ADDR_W-3:0]    OFF_IDX  = 0;
  localparam logic [ADDR_W-3:0]    OFF_DATA = 1;
  localparam logic [PAL_IDX_W-1:0] IDX_ONE  = 1;
  localparam logic [PAL_IDX_W-1:0] IDX_LAST = '1;

  logic                 busyQ;
  logic [PAL_IDX_W-1:0] initCnt;
  logic [PAL_IDX_W-1:0] idxQ;
  phase_e               phaseQ;
  logic                 wrOk, idxHit, dataHit;

  assign wrOk    = busWr && !busyQ && (busBe == 4'hF) && (busAddr[1:0] == 2'b00);
  assign idxHit  = wrOk && (busAddr[ADDR_W-1:2] == OFF_IDX);
  assign dataHit = wrOk && (busAddr[ADDR_W-1:2] == OFF_DATA);
  assign busy    = busyQ;

  always_comb begin
    st.wrComp    = dataHit;
    st.comp      = phaseQ;
    st.wrInit    = busyQ;
    st.initWhite = (initCnt == IDX_LAST);
    st.idx       = busyQ ? initCnt : idxQ;
    st.data      = busWdata[DATA_W-1 -: PAL_COMP_W];
  end

  // initialisation sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b1;
      initCnt <= '0;
    end else if (busyQ) begin
      initCnt <= initCnt + IDX_ONE;
      if (initCnt == IDX_LAST) busyQ <= 1'b0;
    end
  end

  // pointer and component phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ   <= '0;
      phaseQ <= PH_RED;
    end else if (idxHit) begin
      idxQ   <= busWdata[DATA_W-1 -: PAL_IDX_W];
      phaseQ <= PH_RED;
    end else if (dataHit) begin
      unique case (phaseQ)
        PH_RED:  phaseQ <= PH_GRN;
        PH_GRN:  phaseQ <= PH_BLU;
        default: begin
          phaseQ <= PH_RED;
          idxQ   <= idxQ + IDX_ONE;
        end
      endcase
    end
  end

  // R5
  blue_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrComp && phaseQ == PH_BLU) |=> (idxQ == $past(idxQ) + IDX_ONE && phaseQ == PH_RED));
  // R4
  red_to_green_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrComp && phaseQ == PH_RED) |=> phaseQ == PH_GRN);
  // R1
  init_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |=> !busyQ);
  // R7
  ptr_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxHit |=> phaseQ == PH_RED);
endmodule

// File: rtl/palette_dac_store.sv
module palette_dac_store
  import palette_dac_pkg::*;
#(
  localparam int ENTRIES = 1 << PAL_IDX_W,
  localparam int RGB_W   = PAL_NCOMP * PAL_COMP_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pal_strobe_t           st,
  input  logic [PAL_IDX_W-1:0]  lookIdx,
  output logic [RGB_W-1:0]      lookRgb,
  output logic                  updStrobe,
  output logic [PAL_IDX_W-1:0]  updIdx,
  output logic [1:0]            updComp,
  output logic [PAL_COMP_W-1:0] updData
);
  logic [RGB_W-1:0] palMem [ENTRIES];

  genvar c;
  generate
    for (c = 0; c < PAL_NCOMP; c++) begin : g_comp
      localparam int LSB = (PAL_NCOMP - 1 - c) * PAL_COMP_W;
      always_ff @(posedge clk) begin
        if (st.wrInit)
          palMem[st.idx][LSB +: PAL_COMP_W] <= st.initWhite ? '1 : '0;
        else if (st.wrComp && (int'(st.comp) == c))
          palMem[st.idx][LSB +: PAL_COMP_W] <= st.data;
      end
    end
  endgenerate

  assign lookRgb = palMem[lookIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updStrobe <= 1'b0;
      updIdx    <= '0;
      updComp   <= '0;
      updData   <= '0;
    end else begin
      updStrobe <= st.wrComp;
      if (st.wrComp) begin
        updIdx  <= st.idx;
        updComp <= st.comp;
        updData <= st.data;
      end
    end
  end

  // R6
  upd_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> ($past(st.wrComp) && updComp != 2'd3));
  // R11
  no_upd_in_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrInit |=> !updStrobe);
endmodule

// File: rtl/palette_dac_port.sv
module palette_dac_port
  import palette_dac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic [3:0]            busBe,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  busReady,
  output logic                  initBusy,
  output logic                  updStrobe,
  output logic [PAL_IDX_W-1:0]  updIdx,
  output logic [1:0]            updComp,
  output logic [PAL_COMP_W-1:0] updData,
  input  logic [PAL_IDX_W-1:0]  lookIdx,
  output logic [PAL_NCOMP*PAL_COMP_W-1:0] lookRgb
);
  pal_strobe_t st;
  logic        busy;
  logic        rdUnused;

  assign rdUnused = busRd;
  assign busRdata = '0;
  assign busReady = !busy;
  assign initBusy = busy;

  palette_dac_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busBe(busBe), .busy(busy), .st(st)
  );

  palette_dac_store store_i (
    .clk(clk), .rstN(rstN), .st(st), .lookIdx(lookIdx), .lookRgb(lookRgb),
    .updStrobe(updStrobe), .updIdx(updIdx), .updComp(updComp), .updData(updData)
  );

  // R8
  read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> busRdata == '0 || rdUnused == 1'b0);
endmodule

// File: tb/palette_dac_port_tb.sv
module palette_dac_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busBe = 4'hF;
  logic [31:0] busRdata;
  logic        busReady, initBusy, updStrobe;
  logic [7:0]  updIdx, updData, lookIdx = '0;
  logic [1:0]  updComp;
  logic [23:0] lookRgb;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  palette_dac_port dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busBe(busBe), .busRdata(busRdata), .busReady(busReady),
    .initBusy(initBusy), .updStrobe(updStrobe), .updIdx(updIdx), .updComp(updComp),
    .updData(updData), .lookIdx(lookIdx), .lookRgb(lookRgb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write; returns the update pulse seen in the following cycle
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be,
                    output logic [18:0] upd);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d; busBe = be;
    @(negedge clk);
    busWr = 1'b0; busBe = 4'hF;
    upd = {updStrobe, updIdx, updComp, updData};
  endtask

  task automatic look(input logic [7:0] i, output logic [23:0] c);
    lookIdx = i; #1; c = lookRgb;
  endtask

  task automatic t_reset();
    int n = 0;
    logic [18:0] u;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 busy at start", {30'd0, initBusy, busReady}, 32'h2);
    // R11: pointer write offered during init must not land
    wr(4'h0, 32'h0500_0000, 4'hF, u);
    n = 2;
    while (initBusy && n < 400) begin @(negedge clk); n++; end
    chk("R1 init length", n, 256);
    chk("R1 ready after init", {31'd0, busReady}, 1);
  endtask

  task automatic t_init();
    logic [23:0] c;
    look(8'd0, c);   chk("R2 entry0", c, 0);
    look(8'd1, c);   chk("R2 entry1", c, 0);
    look(8'd128, c); chk("R2 entry128", c, 0);
    look(8'd254, c); chk("R2 entry254", c, 0);
    look(8'd255, c); chk("R2 entry255", c, 24'hFFFFFF);
  endtask

  task automatic t_busy_write();
    logic [18:0] u;
    wr(4'h4, 32'h1100_00FF, 4'hF, u);
    chk("R11 pointer untouched by init-time write", u, {1'b1, 8'd0, 2'd0, 8'h11});
    wr(4'h4, 32'h2200_0000, 4'hF, u);
    chk("R6 green pulse", u, {1'b1, 8'd0, 2'd1, 8'h22});
    wr(4'h4, 32'h3300_0000, 4'hF, u);
    chk("R6 blue pulse", u, {1'b1, 8'd0, 2'd2, 8'h33});
    @(negedge clk);
    chk("R6 pulse lasts one cycle", {31'd0, updStrobe}, 0);
  endtask

  task automatic t_triplet();
    logic [18:0] u;
    logic [23:0] c;
    wr(4'h0, 32'h10AB_CDEF, 4'hF, u);
    chk("R3 pointer write no pulse", {31'd0, u[18]}, 0);
    wr(4'h4, 32'hAA12_3456, 4'hF, u);
    chk("R3 pointer from top byte", u, {1'b1, 8'h10, 2'd0, 8'hAA});
    wr(4'h4, 32'hBB00_0000, 4'hF, u);
    wr(4'h4, 32'hCCFF_FFFF, 4'hF, u);
    look(8'h10, c);
    chk("R4 entry colour", c, 24'hAABBCC);
    wr(4'h4, 32'h4400_0000, 4'hF, u);
    chk("R5 next entry red", u, {1'b1, 8'h11, 2'd0, 8'h44});
  endtask

  task automatic t_wrap();
    logic [18:0] u;
    logic [23:0] c;
    wr(4'h0, 32'hFF00_0000, 4'hF, u);
    wr(4'h4, 32'h0100_0000, 4'hF, u);
    wr(4'h4, 32'h0200_0000, 4'hF, u);
    wr(4'h4, 32'h0300_0000, 4'hF, u);
    look(8'hFF, c);
    chk("R4 entry255 rewritten", c, 24'h010203);
    wr(4'h4, 32'h0900_0000, 4'hF, u);
    chk("R5 wrap to 0", u, {1'b1, 8'h00, 2'd0, 8'h09});
  endtask

  task automatic t_midreset();
    logic [18:0] u;
    wr(4'h0, 32'h2000_0000, 4'hF, u);
    wr(4'h4, 32'h5500_0000, 4'hF, u);
    wr(4'h0, 32'h2100_0000, 4'hF, u);
    wr(4'h4, 32'h6600_0000, 4'hF, u);
    chk("R7 restart at red", u, {1'b1, 8'h21, 2'd0, 8'h66});
  endtask

  task automatic t_reads();
    logic [18:0] u;
    @(negedge clk);
    busRd = 1'b1; busAddr = 4'h0; #1;
    chk("R8 read offset0", busRdata, 0);
    busAddr = 4'h4; #1;
    chk("R8 read offset4", busRdata, 0);
    @(negedge clk);
    busRd = 1'b0;
    wr(4'h4, 32'h7700_0000, 4'hF, u);
    chk("R8 phase kept across reads", u, {1'b1, 8'h21, 2'd1, 8'h77});
  endtask

  task automatic t_other_off();
    logic [18:0] u;
    wr(4'h8, 32'h4000_0000, 4'hF, u);
    chk("R9 offset8 no pulse", {31'd0, u[18]}, 0);
    wr(4'hC, 32'h4100_0000, 4'hF, u);
    chk("R9 offset12 no pulse", {31'd0, u[18]}, 0);
    wr(4'h4, 32'h8800_0000, 4'hF, u);
    chk("R9 pointer and phase kept", u, {1'b1, 8'h21, 2'd2, 8'h88});
  endtask

  task automatic t_partial();
    logic [18:0] u;
    wr(4'h0, 32'h6000_0000, 4'h8, u);
    wr(4'h4, 32'h9900_0000, 4'h8, u);
    chk("R10 partial data no pulse", {31'd0, u[18]}, 0);
    wr(4'h4, 32'hAB00_0000, 4'hF, u);
    chk("R10 pointer and phase kept", u, {1'b1, 8'h22, 2'd0, 8'hAB});
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_init();
        t_busy_write();
        t_triplet();
        t_wrap();
        t_midreset();
        t_reads();
        t_other_off();
        t_partial();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule